// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block walks a stream of instruction bytes, one byte per clock under a valid/ready handshake, and marks where each variable-length instruction ends. It sits in front of a full decoder. There it splits the raw fetch stream into whole instructions and reports what each one is made of.

An instruction can have up to six parts, and only the opcode is required. The other parts are leading prefixes, a second opcode byte after an escape, an addressing byte, a scale-index-base byte, a displacement and an immediate. Whether each later part exists, and how long it is, depends on bytes the parser has already taken. For that reason the block is a sequential state machine and not a fixed field splitter.

When the last byte of an instruction has been taken, the block raises a one-cycle done pulse. The pulse carries the total length, the byte count of each part and two error flags. On the next cycle the parser starts looking for prefixes again.

Top module: `insn_len_decoder`

## Requirements
- R1: After reset, `done` is 0 and `in_ready` is 1.
- R2: A byte from the set 0xF0, 0xF2, 0xF3, 0x2E, 0x36, 0x3E, 0x26, 0x64, 0x65, 0x66, 0x67, seen before the opcode, counts as a prefix. Up to four prefixes are accepted and reported in `n_pfx`, and they do not change how the bytes after them are decoded.
- R3: A fifth prefix byte is taken and ends the instruction at once. The result has `err_pfx` = 1, length 5 and `n_pfx` = 5.
- R4: An opcode byte of 0x0F escapes to a second opcode byte, which is looked up in a separate two-byte map (`n_opc` = 2). For example, 0x0F 0x84 carries a 4-byte immediate and 0x0F 0xAF needs an addressing byte.
- R5: The addressing byte splits into mod (bits 7:6) and r/m (bits 2:0). An SIB byte follows it only when mod is not 11 and r/m is 100.
- R6: Displacement size comes from the addressing byte. Mod 01 gives 1 byte, mod 10 gives 4, mod 00 with r/m 101 gives 4, and mod 00 with an SIB whose base (bits 2:0) is 101 gives 4. Every other case gives 0.
- R7: Immediate size (0, 1, 2 or 4 bytes) and the need for an addressing byte come from the opcode. Examples: 0x90 has neither, 0x8B has an addressing byte only, 0x83 has an addressing byte and 1 immediate byte, 0xC7 has an addressing byte and 4 immediate bytes, and 0xC2 has 2 immediate bytes.
- R8: An opcode missing from its map, such as 0xD8 or 0x0F 0x0B, ends the instruction right after the opcode byte and sets `err_unk` = 1.
- R9: `done` lasts exactly one cycle, starting the cycle after the final byte is taken. During that cycle `len` equals the sum of the part counts and `in_ready` is 0. The next cycle `in_ready` is 1 again.
- R10: A cycle with `in_valid` low takes no byte and leaves the parse unchanged, whatever value `in_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| done | output | 1 | One-cycle end-of-instruction pulse |
| len | output | 5 | Total instruction length in bytes |
| n_pfx | output | 3 | Prefix byte count |
| n_opc | output | 2 | Opcode byte count |
| n_modrm | output | 1 | Addressing byte present |
| n_sib | output | 1 | SIB byte present |
| n_disp | output | 3 | Displacement byte count |
| n_imm | output | 3 | Immediate byte count |
| err_pfx | output | 1 | Too many prefixes |
| err_unk | output | 1 | Opcode not in the map |

## Verification
The in-design assertions check these rules on every cycle:
- the reported length always equals the sum of the part counts;
- `done` never lasts more than one cycle and always drops `in_ready`;
- an SIB byte is never reported without an addressing byte;
- the displacement is always 0, 1 or 4 bytes;
- idle cycles leave the parse untouched.

Only the bench scenarios can show that particular byte sequences give the right boundaries, because that depends on what those bytes encode. This covers addressing-byte decoding, the SIB base case, immediate sizes per opcode, the escape map, prefix overflow and unknown opcodes.

// File: rtl/ild_pkg.sv
// Package: shared types for the instruction length decoder.
// Assumes a 32-bit addressing model only; no 16-bit forms.
package ild_pkg;

    typedef enum logic [2:0] {
        S_LEAD  = 3'd0,   // prefixes or first opcode byte
        S_OPC2  = 3'd1,   // second opcode byte after escape
        S_MODRM = 3'd2,
        S_SIB   = 3'd3,
        S_DISP  = 3'd4,
        S_IMM   = 3'd5,
        S_DONE  = 3'd6
    } ild_state_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_B1   = 2'd1,
        IMM_B2   = 2'd2,
        IMM_B4   = 2'd3
    } imm_sz_e;

    localparam logic [7:0] ESCAPE_BYTE = 8'h0F;

    // Convert an immediate size code to a byte count.
    function automatic logic [2:0] imm_bytes(input imm_sz_e s);
        case (s)
            IMM_B1:  imm_bytes = 3'd1;
            IMM_B2:  imm_bytes = 3'd2;
            IMM_B4:  imm_bytes = 3'd4;
            default: imm_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/ild_prefix_class.sv
// Module: ild_prefix_class
// Flags a byte as one of the recognised prefix values.
// Assumes the caller only consults the flag before the opcode.
module ild_prefix_class #(
    parameter int N_CODES = 11
) (
    input  logic [7:0] byte_in,
    output logic       is_prefix
);
    localparam logic [7:0] CODES [N_CODES] = '{
        8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
        8'h26, 8'h64, 8'h65, 8'h66, 8'h67
    };

    logic [N_CODES-1:0] hit;

    // One comparator per prefix code.
    for (genvar i = 0; i < N_CODES; i++) begin : g_cmp
        assign hit[i] = (byte_in == CODES[i]);
    end

    // Any comparator match means prefix.
    always_comb is_prefix = |hit;
endmodule

// File: rtl/ild_opcode_rom.sv
// Module: ild_opcode_rom
// Attribute lookup for a representative opcode subset: whether an
// addressing byte follows and the immediate size. Two maps: the
// one-byte map and the map reached through the 0x0F escape.
// Assumes 32-bit operand size throughout.
module ild_opcode_rom
    import ild_pkg::*;
(
    input  logic       two_byte,
    input  logic [7:0] opc,
    output logic       known,
    output logic       need_modrm,
    output imm_sz_e    imm_sz
);
    // Decode the selected map into attributes.
    always_comb begin
        known      = 1'b1;
        need_modrm = 1'b0;
        imm_sz     = IMM_NONE;
        if (two_byte) begin
            case (opc) inside
                [8'h80:8'h8F]:                     imm_sz = IMM_B4;
                8'hAF, 8'hB6, 8'hB7, 8'hBE, 8'hBF,
                8'h1F:                             need_modrm = 1'b1;
                8'h05:                             ;
                default:                           known = 1'b0;
            endcase
        end else begin
            case (opc) inside
                8'h01, 8'h03, 8'h29, 8'h2B, 8'h31, 8'h33,
                8'h39, 8'h3B, 8'h85, 8'h89, 8'h8B, 8'h8D:
                    need_modrm = 1'b1;
                8'h83, 8'hC6: begin
                    need_modrm = 1'b1;
                    imm_sz     = IMM_B1;
                end
                8'h81, 8'hC7: begin
                    need_modrm = 1'b1;
                    imm_sz     = IMM_B4;
                end
                8'h90, 8'hC3, [8'h50:8'h5F]:   ;
                [8'hB0:8'hB7], [8'h70:8'h7F],
                8'h6A, 8'hEB, 8'h04:           imm_sz = IMM_B1;
                [8'hB8:8'hBF], 8'h68, 8'hE8,
                8'hE9, 8'h05:                  imm_sz = IMM_B4;
                8'hC2:                         imm_sz = IMM_B2;
                default:                       known = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ild_modrm_dec.sv
// Module: ild_modrm_dec
// Decodes the addressing byte (or SIB byte) fields into SIB presence
// and displacement size for 32-bit addressing.
// Assumes in the SIB phase fld_mod holds the saved addressing-byte mod
// and fld_low holds the SIB base field.
module ild_modrm_dec (
    input  logic       sib_phase,
    input  logic [1:0] fld_mod,
    input  logic [2:0] fld_low,
    output logic       sib_next,
    output logic [2:0] disp_b
);
    // Map mod and r/m (or base) to follow-on fields.
    always_comb begin
        sib_next = !sib_phase && (fld_mod != 2'b11) && (fld_low == 3'b100);
        case (fld_mod)
            2'b01:   disp_b = 3'd1;
            2'b10:   disp_b = 3'd4;
            2'b00:   disp_b = (fld_low == 3'b101) ? 3'd4 : 3'd0;
            default: disp_b = 3'd0;
        endcase
        // In the addressing phase, SIB decides displacement later.
        if (sib_next) disp_b = 3'd0;
    end
endmodule

// File: rtl/insn_len_decoder.sv
// Module: insn_len_decoder
// Sequential parser that takes one byte per cycle and reports
// the length and part counts of each variable-length instruction
// with a one-cycle done pulse. in_ready drops only in the done cycle.
// Assumes 32-bit addressing and operand size.
module insn_len_decoder
    import ild_pkg::*;
#(
    parameter int MAX_PFX = 4,
    parameter int MAX_FLD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    output logic       done,
    output logic [$clog2(MAX_PFX+2*MAX_FLD+5)-1:0] len,
    output logic [$clog2(MAX_PFX+2)-1:0]           n_pfx,
    output logic [1:0] n_opc,
    output logic       n_modrm,
    output logic       n_sib,
    output logic [$clog2(MAX_FLD+1)-1:0]           n_disp,
    output logic [$clog2(MAX_FLD+1)-1:0]           n_imm,
    output logic       err_pfx,
    output logic       err_unk
);
    localparam int LEN_W = $clog2(MAX_PFX + 2*MAX_FLD + 5);
    localparam int PFX_W = $clog2(MAX_PFX + 2);
    localparam int FLD_W = $clog2(MAX_FLD + 1);

    ild_state_e state, nxt_state;
    logic [2:0] rem_q, nxt_rem;
    logic [2:0] immb_q, nxt_immb;
    logic [1:0] mod_q;
    logic [LEN_W-1:0] len_q;
    logic [PFX_W-1:0] pfx_q;
    logic [1:0] opc_q;
    logic       modrm_q, sib_q, errp_q, erru_q;
    logic [FLD_W-1:0] disp_q, imm_q;

    logic       accept, is_pfx, known, need_modrm, sib_next;
    logic [2:0] disp_b, opc_immb;
    imm_sz_e    imm_sz;

    ild_prefix_class u_pfx (
        .byte_in   (in_byte),
        .is_prefix (is_pfx)
    );

    ild_opcode_rom u_rom (
        .two_byte   (state == S_OPC2),
        .opc        (in_byte),
        .known      (known),
        .need_modrm (need_modrm),
        .imm_sz     (imm_sz)
    );

    ild_modrm_dec u_mdec (
        .sib_phase (state == S_SIB),
        .fld_mod   ((state == S_SIB) ? mod_q : in_byte[7:6]),
        .fld_low   (in_byte[2:0]),
        .sib_next  (sib_next),
        .disp_b    (disp_b)
    );

    // Handshake: stall only while the result is presented.
    always_comb in_ready = (state != S_DONE);
    always_comb accept   = in_valid && in_ready;
    always_comb opc_immb = imm_bytes(imm_sz);

    // Next state and remaining-field count.
    always_comb begin
        nxt_state = state;
        nxt_rem   = rem_q;
        nxt_immb  = immb_q;
        case (state)
            S_DONE: begin
                nxt_state = S_LEAD;
                nxt_immb  = 3'd0;
            end
            S_LEAD, S_OPC2: begin
                if (accept) begin
                    if (state == S_LEAD && is_pfx) begin
                        if (pfx_q == PFX_W'(MAX_PFX)) nxt_state = S_DONE;
                    end else if (state == S_LEAD && in_byte == ESCAPE_BYTE) begin
                        nxt_state = S_OPC2;
                    end else if (!known) begin
                        nxt_state = S_DONE;
                    end else if (need_modrm) begin
                        nxt_state = S_MODRM;
                        nxt_immb  = opc_immb;
                    end else if (opc_immb != 3'd0) begin
                        nxt_state = S_IMM;
                        nxt_rem   = opc_immb;
                    end else begin
                        nxt_state = S_DONE;
                    end
                end
            end
            S_MODRM, S_SIB: begin
                if (accept) begin
                    if (sib_next) begin
                        nxt_state = S_SIB;
                    end else if (disp_b != 3'd0) begin
                        nxt_state = S_DISP;
                        nxt_rem   = disp_b;
                    end else if (immb_q != 3'd0) begin
                        nxt_state = S_IMM;
                        nxt_rem   = immb_q;
                    end else begin
                        nxt_state = S_DONE;
                    end
                end
            end
            S_DISP: begin
                if (accept) begin
                    if (rem_q == 3'd1) begin
                        if (immb_q != 3'd0) begin
                            nxt_state = S_IMM;
                            nxt_rem   = immb_q;
                        end else begin
                            nxt_state = S_DONE;
                        end
                    end else begin
                        nxt_rem = rem_q - 3'd1;
                    end
                end
            end
            S_IMM: begin
                if (accept) begin
                    if (rem_q == 3'd1) nxt_state = S_DONE;
                    else               nxt_rem   = rem_q - 3'd1;
                end
            end
            default: nxt_state = S_LEAD;
        endcase
    end

    // State, part counters and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_LEAD;
            rem_q   <= '0;
            immb_q  <= '0;
            mod_q   <= '0;
            len_q   <= '0;
            pfx_q   <= '0;
            opc_q   <= '0;
            modrm_q <= 1'b0;
            sib_q   <= 1'b0;
            disp_q  <= '0;
            imm_q   <= '0;
            errp_q  <= 1'b0;
            erru_q  <= 1'b0;
        end else begin
            state  <= nxt_state;
            rem_q  <= nxt_rem;
            immb_q <= nxt_immb;
            if (state == S_DONE) begin
                len_q   <= '0;
                pfx_q   <= '0;
                opc_q   <= '0;
                modrm_q <= 1'b0;
                sib_q   <= 1'b0;
                disp_q  <= '0;
                imm_q   <= '0;
                errp_q  <= 1'b0;
                erru_q  <= 1'b0;
            end else if (accept) begin
                len_q <= len_q + LEN_W'(1);
                case (state)
                    S_LEAD: begin
                        if (is_pfx) begin
                            pfx_q <= pfx_q + PFX_W'(1);
                            if (pfx_q == PFX_W'(MAX_PFX)) errp_q <= 1'b1;
                        end else begin
                            opc_q <= 2'd1;
                            if (in_byte != ESCAPE_BYTE && !known) erru_q <= 1'b1;
                        end
                    end
                    S_OPC2: begin
                        opc_q <= 2'd2;
                        if (!known) erru_q <= 1'b1;
                    end
                    S_MODRM: begin
                        modrm_q <= 1'b1;
                        mod_q   <= in_byte[7:6];
                    end
                    S_SIB:   sib_q  <= 1'b1;
                    S_DISP:  disp_q <= disp_q + FLD_W'(1);
                    S_IMM:   imm_q  <= imm_q + FLD_W'(1);
                    default: ;
                endcase
            end
        end
    end

    // Outputs straight from state and counters.
    always_comb begin
        done    = (state == S_DONE);
        len     = len_q;
        n_pfx   = pfx_q;
        n_opc   = opc_q;
        n_modrm = modrm_q;
        n_sib   = sib_q;
        n_disp  = disp_q;
        n_imm   = imm_q;
        err_pfx = errp_q;
        err_unk = erru_q;
    end

    // R9: reported length matches the part counts it was built from.
    a_r9_len_is_sum: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(len) == 32'(n_pfx) + 32'(n_opc) + 32'(n_modrm)
                 + 32'(n_sib) + 32'(n_disp) + 32'(n_imm)));
    // R9: done is a single-cycle pulse.
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: ready is low while the result is presented.
    a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);
    // R5: SIB never appears without an addressing byte.
    a_r5_sib_needs_modrm: assert property (@(posedge clk) disable iff (!rst_n)
        (done && n_sib) |-> n_modrm);
    // R6: displacement is 0, 1 or 4 bytes.
    a_r6_disp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (n_disp == 0 || n_disp == 1 || n_disp == 4));
    // R3: prefix overflow ends at length MAX_PFX+1.
    a_r3_overflow_len: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_pfx) |-> (32'(len) == MAX_PFX + 1));
    // R8: unknown opcode stops before any operand field.
    a_r8_unk_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_unk) |-> (!n_modrm && n_disp == 0 && n_imm == 0));
    // R10: an idle cycle leaves the parse unchanged.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !done) |=> ($stable(len_q) && $stable(state)));
endmodule

// File: tb/sim_insn_len_decoder.sv
module sim_insn_len_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, done, n_modrm, n_sib, err_pfx, err_unk;
    logic [4:0] len;
    logic [2:0] n_pfx, n_disp, n_imm;
    logic [1:0] n_opc;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] stim [0:15];
    int stim_n = 0;

    insn_len_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .done(done), .len(len), .n_pfx(n_pfx),
        .n_opc(n_opc), .n_modrm(n_modrm), .n_sib(n_sib), .n_disp(n_disp),
        .n_imm(n_imm), .err_pfx(err_pfx), .err_unk(err_unk)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        stim[stim_n] = b;
        stim_n++;
    endtask

    // Feed the queued bytes (with optional idle gaps), then check the done cycle.
    task automatic run_insn(input string req, input int gap,
                            input int e_len, input int e_pfx, input int e_opc,
                            input int e_mrm, input int e_sib, input int e_disp,
                            input int e_imm, input int e_ep, input int e_eu);
        for (int i = 0; i < stim_n; i++) begin
            @(negedge clk);
            for (int g = 0; g < gap; g++) begin
                in_valid = 1'b0;
                in_byte  = 8'hF0;
                @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_byte  = stim[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(done == 1'b1, req, "done", int'(done), 1);
        chk(int'(len) == e_len, req, "len", int'(len), e_len);
        chk(int'(n_pfx) == e_pfx && int'(n_opc) == e_opc, req, "pfx*10+opc",
            int'(n_pfx)*10 + int'(n_opc), e_pfx*10 + e_opc);
        chk(int'(n_modrm) == e_mrm && int'(n_sib) == e_sib, req, "modrm*10+sib",
            int'(n_modrm)*10 + int'(n_sib), e_mrm*10 + e_sib);
        chk(int'(n_disp) == e_disp && int'(n_imm) == e_imm, req, "disp*10+imm",
            int'(n_disp)*10 + int'(n_imm), e_disp*10 + e_imm);
        chk(int'(err_pfx) == e_ep && int'(err_unk) == e_eu, req, "errp*10+erru",
            int'(err_pfx)*10 + int'(err_unk), e_ep*10 + e_eu);
        chk(in_ready == 1'b0, "R9", "ready in done", int'(in_ready), 0);
        @(negedge clk);
        chk(done == 1'b0 && in_ready == 1'b1, "R9", "done*10+ready after",
            int'(done)*10 + int'(in_ready), 1);
        stim_n = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && in_ready == 1'b1, "R1", "done*10+ready",
            int'(done)*10 + int'(in_ready), 1);
        rst_n = 1'b1;
    endtask

    task automatic t_plain();
        push(8'h90);
        run_insn("R7", 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_prefixes();
        push(8'hF0); push(8'hF3); push(8'h2E); push(8'h66); push(8'h89); push(8'hC8);
        run_insn("R2", 0, 6, 4, 1, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_pfx_overflow();
        for (int i = 0; i < 5; i++) push(8'hF0);
        run_insn("R3", 0, 5, 5, 0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_escape();
        push(8'h0F); push(8'h84); push(8'h10); push(8'h00); push(8'h00); push(8'h00);
        run_insn("R4", 0, 6, 0, 2, 0, 0, 0, 4, 0, 0);
        push(8'h0F); push(8'hAF); push(8'h04); push(8'h24);
        run_insn("R4", 0, 4, 0, 2, 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_sib_rules();
        // mod 11 r/m 100: register form, no SIB
        push(8'h8B); push(8'hC4);
        run_insn("R5", 0, 2, 0, 1, 1, 0, 0, 0, 0, 0);
        // mod 00 r/m 100 with SIB base 100: SIB, no displacement
        push(8'h8B); push(8'h04); push(8'h24);
        run_insn("R5", 0, 3, 0, 1, 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_disp_rules();
        push(8'h8B); push(8'h45); push(8'hF8);
        run_insn("R6", 0, 3, 0, 1, 1, 0, 1, 0, 0, 0);
        push(8'h8B); push(8'h80); push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        run_insn("R6", 0, 6, 0, 1, 1, 0, 4, 0, 0, 0);
        push(8'h8B); push(8'h05); push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        run_insn("R6", 0, 6, 0, 1, 1, 0, 4, 0, 0, 0);
        push(8'h8B); push(8'h04); push(8'h25);
        push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        run_insn("R6", 0, 7, 0, 1, 1, 1, 4, 0, 0, 0);
    endtask

    task automatic t_immediates();
        push(8'h83); push(8'hC0); push(8'h01);
        run_insn("R7", 0, 3, 0, 1, 1, 0, 0, 1, 0, 0);
        push(8'hC2); push(8'h08); push(8'h00);
        run_insn("R7", 0, 3, 0, 1, 0, 0, 0, 2, 0, 0);
        push(8'hC7); push(8'h44); push(8'h24); push(8'h08);
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        run_insn("R7", 0, 8, 0, 1, 1, 1, 1, 4, 0, 0);
    endtask

    task automatic t_longest();
        for (int i = 0; i < 4; i++) push(8'hF0);
        push(8'hC7); push(8'h84); push(8'h24);
        for (int i = 0; i < 8; i++) push(8'(i));
        run_insn("R2", 0, 15, 4, 1, 1, 1, 4, 4, 0, 0);
    endtask

    task automatic t_unknown();
        push(8'hF3); push(8'hD8);
        run_insn("R8", 0, 2, 1, 1, 0, 0, 0, 0, 0, 1);
        push(8'h0F); push(8'h0B);
        run_insn("R8", 0, 2, 0, 2, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_idle_gaps();
        // Idle cycles carry a prefix value that must not be taken.
        push(8'h8B); push(8'h45); push(8'hF8);
        run_insn("R10", 2, 3, 0, 1, 1, 0, 1, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_prefixes();
        t_pfx_overflow();
        t_escape();
        t_sib_rules();
        t_disp_rules();
        t_immediates();
        t_longest();
        t_unknown();
        t_idle_gaps();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule